// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one timer channel: a prescaled counter that runs up or down between zero and a reload limit, plus one output-compare stage. A small register port loads the prescaler, the reload limit, the compare value and the channel settings. A read port returns the settings. Each time the counter takes a new value, that value is compared with the compare register. One of eight modes then shapes a reference level from the result. The mode set covers hold, set, clear, toggle, two forced levels and two pulse-width modes.

The output pin carries the reference level after the polarity and enable settings. A compare event sets a sticky match flag. It can also raise a one-cycle interrupt pulse and a one-cycle DMA request pulse, each with its own enable. All pins are plain control and status signals: there is no data stream, so no valid/ready handshake is used.

Top module: `tmr_oc_chan`

## Requirements
- R1: After reset, all of these read as zero: the counter, reference, pin, flag, interrupt and DMA outputs, and the CTRL (addr 0), CHCFG (addr 4) and IEN (addr 5) registers. The reload register ARR (addr 2) resets to all ones.
- R2: While CTRL bit 0 (run) is 1, the counter takes one step every PSC+1 clock cycles, where PSC is the prescaler at addr 1. While run is 0, the counter holds its value.
- R3: With CTRL bit 1 (down) at 0, the counter steps up and goes from ARR to 0. With down at 1, it steps down and goes from 0 to ARR.
- R4: CHCFG bits 2:0 select the mode. In mode 0 (hold), a compare event leaves the reference unchanged, but the event still sets the flag.
- R5: In mode 1, the reference becomes 1 on the compare event. In mode 2, it becomes 0 on the event. It keeps that level until the next event. The event occurs on the clock edge at which the counter steps to a value equal to CMP (addr 3).
- R6: In mode 3, the reference inverts on every compare event.
- R7: In mode 4 the reference is 0, and in mode 5 it is 1, whatever the counter value.
- R8: In mode 6, the reference is (count < CMP) when counting up and (count <= CMP) when counting down. Mode 7 gives the inverse of mode 6 in both directions.
- R9: CHCFG bit 3 is the polarity and bit 4 is the output enable. With the enable at 1, pin = reference XOR polarity. With the enable at 0, pin = polarity.
- R10: The STAT flag (addr 6, bit 0) is set by every compare event. Writing 0 to it clears it, and writing 1 has no effect. A set in the same cycle as a clear wins.
- R11: On a compare event, the interrupt output pulses for one cycle if IEN bit 0 is 1. The DMA output pulses if IEN bit 1 is 1. With the enable at 0, the output does not pulse.
- R12: CHCFG bits 6:5 (direction select) take a write only while the output enable is 0 before that write. Otherwise they keep their value, while the other CHCFG fields still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| cnt_o | output | CNT_W | Current counter value |
| ref_o | output | 1 | Reference level before polarity and enable |
| pin_o | output | 1 | Channel output pin level |
| flag_o | output | 1 | Sticky compare-match flag |
| irq_o | output | 1 | Interrupt pulse |
| dma_o | output | 1 | DMA request pulse |

## Verification
The single-cycle pulse property assumes that ARR and PSC are never both zero. If they were, the counter would sit on the compare value and produce an event on every cycle. The range property assumes that ARR is never lowered below a running count. The stimulus writes ARR=9 once, while the counter is stopped at zero, and only changes PSC, modes and enables after that. As a result, every compare event in the run is at least ten cycles from the next.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    OCM_HOLD     = 3'd0,
    OCM_SET      = 3'd1,
    OCM_CLR      = 3'd2,
    OCM_TOGGLE   = 3'd3,
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_A    = 3'd6,
    OCM_PWM_B    = 3'd7
  } ocm_e;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_PSC   = 3'd1,
    RA_ARR   = 3'd2,
    RA_CMP   = 3'd3,
    RA_CHCFG = 3'd4,
    RA_IEN   = 3'd5,
    RA_STAT  = 3'd6
  } regaddr_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  input  logic             match_evt,
  output logic [CNT_W-1:0] rd_data,
  output logic             run,
  output logic             down,
  output logic [CNT_W-1:0] psc,
  output logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cmp,
  output ocm_e             mode,
  output logic             pol,
  output logic             oe,
  output logic             ien,
  output logic             den,
  output logic             flag
);

  logic [1:0] dirsel;
  logic       stat_clr;

  assign stat_clr = wr_en && (regaddr_e'(wr_addr) == RA_STAT) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      down   <= 1'b0;
      psc    <= '0;
      arr    <= '1;
      cmp    <= '0;
      mode   <= OCM_HOLD;
      pol    <= 1'b0;
      oe     <= 1'b0;
      dirsel <= 2'b00;
      ien    <= 1'b0;
      den    <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (regaddr_e'(wr_addr))
          RA_CTRL: begin
            run  <= wr_data[0];
            down <= wr_data[1];
          end
          RA_PSC: psc <= wr_data;
          RA_ARR: arr <= wr_data;
          RA_CMP: cmp <= wr_data;
          RA_CHCFG: begin
            mode <= ocm_e'(wr_data[2:0]);
            pol  <= wr_data[3];
            oe   <= wr_data[4];
            if (!oe) dirsel <= wr_data[6:5];
          end
          RA_IEN: begin
            ien <= wr_data[0];
            den <= wr_data[1];
          end
          default: ;
        endcase
      end
      // set beats clear when both land in one cycle
      if (match_evt)     flag <= 1'b1;
      else if (stat_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (regaddr_e'(rd_addr))
      RA_CTRL:  rd_data[1:0] = {down, run};
      RA_PSC:   rd_data      = psc;
      RA_ARR:   rd_data      = arr;
      RA_CMP:   rd_data      = cmp;
      RA_CHCFG: rd_data[6:0] = {dirsel, oe, pol, mode};
      RA_IEN:   rd_data[1:0] = {den, ien};
      RA_STAT:  rd_data[0]   = flag;
      default:  rd_data      = '0;
    endcase
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             down,
  input  logic [CNT_W-1:0] psc,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick
);

  logic [CNT_W-1:0] pre_q;

  // >= keeps the divider sane when PSC is lowered mid-period
  assign tick = run && (pre_q >= psc);

  always_comb begin
    if (down) cnt_nxt = (cnt == '0) ? arr : cnt - 1'b1;
    else      cnt_nxt = (cnt >= arr) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        cnt   <= cnt_nxt;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_oc.sv
module tmr_oc
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ocm_e             mode,
  input  logic             pol,
  input  logic             oe,
  input  logic             down,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             evt,
  output logic             ref_o,
  output logic             pin_o
);

  logic ref_q;
  logic lvl;
  logic pwm_a;

  // level modes follow the live count
  assign pwm_a = down ? (cnt <= cmp) : (cnt < cmp);

  always_comb begin
    case (mode)
      OCM_FORCE_LO: lvl = 1'b0;
      OCM_FORCE_HI: lvl = 1'b1;
      OCM_PWM_A:    lvl = pwm_a;
      OCM_PWM_B:    lvl = !pwm_a;
      default:      lvl = ref_q;
    endcase
  end

  // event modes keep state; level modes refresh it so HOLD retains the last level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      case (mode)
        OCM_SET:    if (evt) ref_q <= 1'b1;
        OCM_CLR:    if (evt) ref_q <= 1'b0;
        OCM_TOGGLE: if (evt) ref_q <= !ref_q;
        OCM_HOLD:   ;
        default:    ref_q <= lvl;
      endcase
    end
  end

  assign ref_o = mode[2] ? lvl : ref_q;
  assign pin_o = oe ? (ref_o ^ pol) : pol;

endmodule

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o,
  output logic             pin_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             dma_o
);

  logic             run, down, pol, oe, ien, den;
  logic [CNT_W-1:0] psc, arr, cmp, cnt_nxt;
  logic             tick, match_evt;
  ocm_e             mode;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .match_evt, .rd_data, .run, .down, .psc, .arr, .cmp,
    .mode, .pol, .oe, .ien, .den, .flag(flag_o)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .run, .down, .psc, .arr,
    .cnt(cnt_o), .cnt_nxt, .tick
  );

  // event lands on the edge where the counter takes the compare value
  assign match_evt = tick && (cnt_nxt == cmp);

  tmr_oc #(.CNT_W(CNT_W)) u_oc (
    .clk, .rst_n, .mode, .pol, .oe, .down,
    .cnt(cnt_o), .cmp, .evt(match_evt), .ref_o, .pin_o
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      dma_o <= 1'b0;
    end else begin
      irq_o <= match_evt && ien;
      dma_o <= match_evt && den;
    end
  end

endmodule

// File: rtl/tmr_oc_chan_chk.sv
module tmr_oc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             oe,
  input logic             pol,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ref_o,
  input logic             pin_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             dma_o
);

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_o));

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= arr);

  a_r5_set_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && $past(mode) == 3'd1 && $past(ref_o)) |-> ref_o);

  a_r7_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |-> ref_o);

  a_r7_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd4 |-> !ref_o);

  a_r9_pin_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (pin_o == pol));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r11_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || dma_o) |-> flag_o);

endmodule

bind tmr_oc_chan tmr_oc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .oe(oe), .pol(pol), .mode(mode),
  .arr(arr), .cnt_o(cnt_o), .ref_o(ref_o), .pin_o(pin_o), .flag_o(flag_o),
  .irq_o(irq_o), .dma_o(dma_o)
);

// File: tb/tmr_oc_chan_tb.sv
module tmr_oc_chan_tb;

  localparam int CW = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_ARR = 3'd2, A_CMP = 3'd3,
                         A_CHCFG = 3'd4, A_IEN = 3'd5, A_STAT = 3'd6;
  localparam int TOP = 9;
  localparam int CV  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data, cnt_o;
  logic          ref_o, pin_o, flag_o, irq_o, dma_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int cnt; bit irq; bit dma; } ev_t;
  ev_t sb_q[$];

  always #2 clk = !clk;

  tmr_oc_chan #(.CNT_W(CW)) u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data, .cnt_o, .ref_o, .pin_o, .flag_o, .irq_o, .dma_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, int exp);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic wait_cnt(int v);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (int'(cnt_o) != v && t < 1000);
    if (t >= 1000) chk("R3 count never reached target", int'(cnt_o), v);
  endtask

  // monitor: every interrupt or DMA pulse must match the next expected event
  always @(negedge clk) begin
    if (rst_n && (irq_o || dma_o)) begin
      if (sb_q.size() == 0) begin
        chk("R11 unexpected pulse irq/dma", {irq_o, dma_o}, 0);
      end else begin
        ev_t e;
        e = sb_q.pop_front();
        chk("R11 pulse count value", int'(cnt_o), e.cnt);
        chk("R11 irq pulse", int'(irq_o), int'(e.irq));
        chk("R11 dma pulse", int'(dma_o), int'(e.dma));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 ref", int'(ref_o), 0);
    chk("R1 pin", int'(pin_o), 0);
    chk("R1 flag", int'(flag_o), 0);
    chk("R1 irq/dma", {irq_o, dma_o}, 0);
    rd_chk("R1 CTRL", A_CTRL, 0);
    rd_chk("R1 CHCFG", A_CHCFG, 0);
    rd_chk("R1 IEN", A_IEN, 0);
    rd_chk("R1 ARR", A_ARR, 16'hFFFF);

    // R5 set on match, R11 both pulses
    wr(A_PSC, 0);
    wr(A_ARR, TOP);
    wr(A_CMP, CV);
    wr(A_CHCFG, 'h11);
    wr(A_IEN, 3);
    sb_q.push_back('{cnt: CV, irq: 1'b1, dma: 1'b1});
    wr(A_CTRL, 1);
    wait_cnt(CV);
    chk("R5 set mode ref", int'(ref_o), 1);
    chk("R9 pin follows ref", int'(pin_o), 1);
    chk("R10 flag set", int'(flag_o), 1);
    @(negedge clk);
    chk("R11 irq single cycle", int'(irq_o), 0);
    chk("R5 set level held", int'(ref_o), 1);
    wr(A_IEN, 0);

    // R5 clear on match
    wr(A_CHCFG, 'h12);
    wait_cnt(CV - 1);
    chk("R5 clear mode before event", int'(ref_o), 1);
    @(negedge clk);
    chk("R5 count at event", int'(cnt_o), CV);
    chk("R5 clear mode ref", int'(ref_o), 0);

    // R10 write 1 keeps, write 0 clears
    wr(A_STAT, 1);
    chk("R10 write one ignored", int'(flag_o), 1);
    wr(A_STAT, 0);
    chk("R10 write zero clears", int'(flag_o), 0);

    // R6 toggle
    wr(A_CHCFG, 'h13);
    wait_cnt(CV);
    chk("R6 toggle first", int'(ref_o), 1);
    wait_cnt(CV);
    chk("R6 toggle second", int'(ref_o), 0);

    // R4 hold mode
    wr(A_CHCFG, 'h10);
    wr(A_STAT, 0);
    chk("R4 flag cleared", int'(flag_o), 0);
    wait_cnt(CV);
    chk("R4 hold ref unchanged", int'(ref_o), 0);
    chk("R4 flag still set", int'(flag_o), 1);

    // R7 forced levels
    wr(A_CHCFG, 'h15);
    chk("R7 forced high", int'(ref_o), 1);
    wr(A_CHCFG, 'h14);
    chk("R7 forced low", int'(ref_o), 0);

    // R9 polarity and enable
    wr(A_CHCFG, 'h1D);
    chk("R9 active-low enabled", int'(pin_o), 0);
    wr(A_CHCFG, 'h0D);
    chk("R9 active-low disabled", int'(pin_o), 1);
    wr(A_CHCFG, 'h05);
    chk("R9 active-high disabled", int'(pin_o), 0);

    // R12 direction select write gating
    wr(A_CHCFG, 'h45);
    rd_chk("R12 dirsel while disabled", A_CHCFG, 'h45);
    wr(A_CHCFG, 'h55);
    rd_chk("R12 enable set", A_CHCFG, 'h55);
    wr(A_CHCFG, 'h74);
    rd_chk("R12 dirsel ignored while enabled", A_CHCFG, 'h54);

    // R8 PWM up, R3 up wrap
    wr(A_CHCFG, 'h16);
    for (int i = 0; i < 12; i++) begin
      c0 = int'(cnt_o);
      @(negedge clk);
      chk("R3 up step", int'(cnt_o), (c0 == TOP) ? 0 : c0 + 1);
      chk("R8 pwm1 up", int'(ref_o), int'(int'(cnt_o) < CV));
    end
    wr(A_CHCFG, 'h17);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 pwm2 up", int'(ref_o), int'(int'(cnt_o) >= CV));
    end

    // R3 down wrap, R8 in down direction
    wr(A_CTRL, 3);
    for (int i = 0; i < 12; i++) begin
      c0 = int'(cnt_o);
      @(negedge clk);
      chk("R3 down step", int'(cnt_o), (c0 == 0) ? TOP : c0 - 1);
      chk("R8 pwm2 down", int'(ref_o), int'(int'(cnt_o) > CV));
    end
    wr(A_CHCFG, 'h16);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 pwm1 down", int'(ref_o), int'(int'(cnt_o) <= CV));
    end

    // R2 stop and prescale
    wr(A_CTRL, 0);
    c0 = int'(cnt_o);
    repeat (5) @(negedge clk);
    chk("R2 held while stopped", int'(cnt_o), c0);
    wr(A_PSC, 2);
    wr(A_CTRL, 1);
    c0 = int'(cnt_o);
    for (int t = 0; t < 10 && int'(cnt_o) == c0; t++) @(negedge clk);
    c1 = int'(cnt_o);
    @(negedge clk);
    chk("R2 prescale hold 1", int'(cnt_o), c1);
    @(negedge clk);
    chk("R2 prescale hold 2", int'(cnt_o), c1);
    @(negedge clk);
    chk("R2 prescale step", int'(cnt_o), (c1 == TOP) ? 0 : c1 + 1);

    // R11 DMA only
    wr(A_PSC, 0);
    wr(A_IEN, 2);
    sb_q.push_back('{cnt: CV, irq: 1'b0, dma: 1'b1});
    wait_cnt(CV);
    @(negedge clk);
    wr(A_IEN, 0);
    repeat (12) @(negedge clk);
    chk("R11 all expected pulses seen", sb_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule